// File: doc/BRIEF.md
# Multi-Source Frame Packer

This block gathers 32-bit words from up to four independent producers and packs them into 256-bit frames for a wide buffer on the host-bound path. The producers are the received-packet path, the configuration-response path, a loopback path and the command-response path. Each producer offers one word at a time with a valid/ready handshake and marks the final word of each packet.

Each frame carries eight 32-bit words. Word 0 is a self-describing status word. Words 1 to 7 are data slots. For every data slot, the status word records which producer filled it, whether it holds data, and whether it ends a packet. Producers are served in rotating order, one word per cycle. Once a producer has started a packet, it keeps the slot stream until that packet's last word, so packet words stay contiguous.

A frame that is only partly filled is released after a programmable number of idle cycles. A finished frame waits in an output register until the consumer takes it. While the output register is full and not being taken, nothing is accepted from any producer.

Top module: `mpk_merge_packer`

## Requirements
- R1: While `rst` is high, `out_valid` and every bit of `src_ready` are 0. This holds even when producers present valid words.
- R2: Frame layout. The status word is `out_data[31:0]`. Data slot k (k = 0..6, in order of acceptance) is `out_data[32*(k+1)+31 : 32*(k+1)]`.
- R3: Slot k of the status word is described by the 4-bit field at bits `[4k+3:4k]`. Bits [1:0] hold the producer index, bit 2 is valid, and bit 3 is last-of-packet. Unused slots have an all-zero field and all-zero data.
- R4: Bits [31:28] of the status word always hold the sync marker 4'hA.
- R5: The clock edge that accepts the seventh word of a frame loads the frame into the output register. `out_valid` is 1 from that edge on, and the next word goes to slot 0 of a new frame.
- R6: With no packet in progress, the grant goes to the first requesting producer found by searching upward, with wrap, from the producer after the one granted last. The search starts at producer 0 after reset.
- R7: After a word with last = 0 is accepted from producer p, no other producer is granted until a word with last = 1 has been accepted from p.
- R8: Consider a partly filled frame with the output free. An idle cycle is one with no word accepted. On the idle cycle whose consecutive count reaches `cfg_idle_limit` (a limit of 0 behaves as 1), the frame is emitted. The idle count restarts on every accepted word.
- R9: While `out_valid` is 1 and `out_ready` is 0, `src_ready` is all zero and `out_data` does not change.
- R10: At most one bit of `src_ready` is 1 in any cycle, and only for a producer whose `src_valid` is 1. A word transfers on an edge where both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 4 | Per-producer word valid |
| src_data | input | 128 | Producer words; producer i at bits [32i+31:32i] |
| src_last | input | 4 | Per-producer last-word-of-packet flag |
| src_ready | output | 4 | Per-producer accept strobe |
| cfg_idle_limit | input | 16 | Idle cycles before a partial frame is released |
| out_valid | output | 1 | Frame available |
| out_data | output | 256 | Packed frame: status word plus seven data slots |
| out_ready | input | 1 | Consumer takes the frame |

## Verification
Several properties are checked on every cycle by the assertions: the sync marker in every presented frame, at most one strobe and only for a valid producer, no strobes and a frozen frame during back-pressure, the packet hold after a non-final word, the fill count range, and that an idle release never fires on an empty frame. Other behaviour depends on history and is shown only by the bench's reference model across its scenarios. This covers the exact rotating order after each grant, the exact slot contents and field codes, and the exact cycle on which the idle limit releases a partial frame, including limits of 0 and 1.

// File: rtl/mpk_pkg.sv
package mpk_pkg;

    localparam int DW        = 32;
    localparam int FRAME_DW  = 8;
    localparam int SLOTS     = FRAME_DW - 1;
    localparam int FRAME_W   = DW * FRAME_DW;
    localparam int SRC_W     = 2;
    localparam int MAX_SRC   = 1 << SRC_W;
    localparam int FILL_W    = $clog2(SLOTS + 1);
    localparam logic [3:0] SYNC_MARK = 4'hA;

    typedef logic [DW-1:0] dword_t;

    typedef struct packed {
        logic             last;
        logic             vld;
        logic [SRC_W-1:0] src;
    } slot_tag_t;

    typedef slot_tag_t [SLOTS-1:0] tag_vec_t;
    typedef dword_t    [SLOTS-1:0] dat_vec_t;

    function automatic dword_t make_status(tag_vec_t tags);
        return {SYNC_MARK, tags};
    endfunction

endpackage

// File: rtl/mpk_rr_arbiter.sv
module mpk_rr_arbiter
    import mpk_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] last,
    output logic             gnt_vld,
    output logic [SRC_W-1:0] gnt_idx,
    output logic             gnt_last
);

    logic [SRC_W-1:0] ptr_q;
    logic [SRC_W-1:0] owner_q;
    logic             lock_q;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        if (en) begin
            if (lock_q) begin
                if (req[owner_q]) begin
                    gnt_vld = 1'b1;
                    gnt_idx = owner_q;
                end
            end else begin
                for (int i = 0; i < N_SRC; i++) begin
                    if (!gnt_vld && req[(int'(ptr_q) + i) % N_SRC]) begin
                        gnt_vld = 1'b1;
                        gnt_idx = SRC_W'((int'(ptr_q) + i) % N_SRC);
                    end
                end
            end
        end
    end

    assign gnt_last = last[gnt_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            owner_q <= '0;
            lock_q  <= 1'b0;
        end else if (gnt_vld) begin
            ptr_q   <= SRC_W'((int'(gnt_idx) + 1) % N_SRC);
            owner_q <= gnt_idx;
            lock_q  <= !gnt_last;
        end
    end

    // R7: a non-final word keeps the grant on the same producer
    assert_tlp_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (gnt_vld && !gnt_last) |=> (!gnt_vld || gnt_idx == $past(gnt_idx)));

endmodule

// File: rtl/mpk_idle_timer.sv
module mpk_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign expire  = idle && (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clr || expire) begin
            cnt_q <= '0;
        end else if (idle) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    // R8: idle and accept never coincide
    assert_idle_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(idle && clr));

endmodule

// File: rtl/mpk_frame_builder.sv
module mpk_frame_builder
    import mpk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               advance,
    input  logic               wr_en,
    input  dword_t             wr_data,
    input  slot_tag_t          wr_tag,
    input  logic               flush,
    output logic               fill_busy,
    output logic               out_valid,
    output logic [FRAME_W-1:0] out_data
);

    logic [FILL_W-1:0] fill_q;
    tag_vec_t          tags_q, tags_n;
    dat_vec_t          dat_q, dat_n;
    logic              emit;
    logic [FRAME_W-1:0] frame;

    always_comb begin
        tags_n = tags_q;
        dat_n  = dat_q;
        if (wr_en) begin
            tags_n[fill_q] = wr_tag;
            dat_n[fill_q]  = wr_data;
        end
    end

    assign emit      = flush || (wr_en && fill_q == FILL_W'(SLOTS - 1));
    assign frame     = {dat_n, make_status(tags_n)};
    assign fill_busy = (fill_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q    <= '0;
            tags_q    <= '0;
            dat_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (advance) begin
            out_valid <= emit;
            if (emit) begin
                out_data <= frame;
                fill_q   <= '0;
                tags_q   <= '0;
                dat_q    <= '0;
            end else if (wr_en) begin
                fill_q <= fill_q + 1'b1;
                tags_q <= tags_n;
                dat_q  <= dat_n;
            end
        end
    end

    // R9: a held frame stays put
    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !advance) |=> (out_valid && $stable(out_data)));

    // R5: the fill count never reaches a full frame without emitting
    assert_fill_range_R5: assert property (@(posedge clk) disable iff (rst)
        fill_q < FILL_W'(SLOTS));

    // R8: a release only happens with data pending
    assert_flush_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
        flush |-> fill_busy);

endmodule

// File: rtl/mpk_merge_packer.sv
module mpk_merge_packer
    import mpk_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int IDLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_SRC-1:0]      src_valid,
    input  logic [N_SRC*DW-1:0]   src_data,
    input  logic [N_SRC-1:0]      src_last,
    output logic [N_SRC-1:0]      src_ready,
    input  logic [IDLE_W-1:0]     cfg_idle_limit,
    output logic                  out_valid,
    output logic [FRAME_W-1:0]    out_data,
    input  logic                  out_ready
);

    logic             advance;
    logic             gnt_vld;
    logic [SRC_W-1:0] gnt_idx;
    logic             gnt_last;
    logic             fill_busy;
    logic             expire;
    dword_t           src_words [N_SRC];
    slot_tag_t        wr_tag;

    assign advance = !rst && (!out_valid || out_ready);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign src_words[i] = src_data[i*DW +: DW];
        assign src_ready[i] = gnt_vld && (gnt_idx == SRC_W'(i));
    end

    mpk_rr_arbiter #(.N_SRC(N_SRC)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .en       (advance),
        .req      (src_valid),
        .last     (src_last),
        .gnt_vld  (gnt_vld),
        .gnt_idx  (gnt_idx),
        .gnt_last (gnt_last)
    );

    mpk_idle_timer #(.CNT_W(IDLE_W)) u_idle (
        .clk    (clk),
        .rst    (rst),
        .idle   (advance && !gnt_vld && fill_busy),
        .clr    (gnt_vld),
        .limit  (cfg_idle_limit),
        .expire (expire)
    );

    assign wr_tag = '{last: gnt_last, vld: 1'b1, src: gnt_idx};

    mpk_frame_builder u_frame (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .wr_en     (gnt_vld),
        .wr_data   (src_words[gnt_idx]),
        .wr_tag    (wr_tag),
        .flush     (expire),
        .fill_busy (fill_busy),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R10: one strobe at most, only toward a valid producer
    assert_ready_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_ready));
    assert_ready_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
        (src_ready & ~src_valid) == '0);

    // R9: nothing accepted while the frame is held
    assert_no_take_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> (src_ready == '0));

    // R4: sync marker on every presented frame
    assert_sync_mark_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[31:28] == SYNC_MARK));

    // R3: a presented frame always has its first slot filled
    assert_slot0_filled_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data[2]);

endmodule

// File: tb/test_mpk_merge_packer.sv
module test_mpk_merge_packer;

    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   src_valid = '0;
    logic [N*32-1:0] src_data = '0;
    logic [N-1:0]   src_last = '0;
    logic [N-1:0]   src_ready;
    logic [15:0]    cfg_idle_limit = 16'd5;
    logic           out_valid;
    logic [255:0]   out_data;
    logic           out_ready = 1'b0;

    always #2 clk = ~clk;

    mpk_merge_packer i_mpk_merge_packer (
        .clk            (clk),
        .rst            (rst),
        .src_valid      (src_valid),
        .src_data       (src_data),
        .src_last       (src_last),
        .src_ready      (src_ready),
        .cfg_idle_limit (cfg_idle_limit),
        .out_valid      (out_valid),
        .out_data       (out_data),
        .out_ready      (out_ready)
    );

    int errors = 0;
    int checks = 0;
    int p_valid = 0;
    int p_ready = 100;
    int frames_seen = 0;
    logic [32:0] srcq [N][$];

    // behavioural reference state
    int           m_cnt = 0, m_idle = 0, m_ptr = 0, m_owner = 0;
    bit           m_lock = 0, m_ov = 0;
    logic [3:0]   m_fld [7];
    logic [31:0]  m_dat [7];
    logic [255:0] m_od = '0;

    task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic int m_grant();
        if (rst) return -1;
        if (m_ov && !out_ready) return -1;
        if (m_lock) return src_valid[m_owner] ? m_owner : -1;
        for (int i = 0; i < N; i++)
            if (src_valid[(m_ptr + i) % N]) return (m_ptr + i) % N;
        return -1;
    endfunction

    task automatic m_clear();
        for (int k = 0; k < 7; k++) begin
            m_fld[k] = '0;
            m_dat[k] = '0;
        end
        m_cnt  = 0;
        m_idle = 0;
    endtask

    // reference model step on every edge
    always @(posedge clk) begin
        int g;
        bit emit;
        int lim;
        g = m_grant();
        if (rst) begin
            m_clear();
            m_ptr = 0; m_owner = 0; m_lock = 0; m_ov = 0;
        end else if (!m_ov || out_ready) begin
            emit = 0;
            lim  = (cfg_idle_limit == 0) ? 1 : int'(cfg_idle_limit);
            if (g >= 0) begin
                m_fld[m_cnt] = {src_last[g], 1'b1, 2'(g)};
                m_dat[m_cnt] = src_data[g*32 +: 32];
                m_cnt++;
                m_idle  = 0;
                m_ptr   = (g + 1) % N;
                m_owner = g;
                m_lock  = !src_last[g];
                void'(srcq[g].pop_front());
                if (m_cnt == 7) emit = 1;
            end else if (m_cnt > 0) begin
                if (m_idle + 1 >= lim) emit = 1;
                else m_idle++;
            end
            if (emit) begin
                m_od[31:28] = 4'hA;
                for (int k = 0; k < 7; k++) begin
                    m_od[4*k +: 4]       = m_fld[k];
                    m_od[32*(k+1) +: 32] = m_dat[k];
                end
                m_ov = 1;
                m_clear();
            end else begin
                m_ov = 0;
            end
        end
    end

    // compare at the falling edge, then drive the next inputs
    initial begin
        forever begin
            @(negedge clk);
            begin
                int g;
                logic [3:0] exp_rdy;
                g = m_grant();
                exp_rdy = (g >= 0) ? (4'b1 << g) : 4'b0;
                if (rst) begin
                    chk(out_valid == 1'b0 && src_ready == '0, "R1", "reset outputs",
                        {src_ready, out_valid}, '0);
                end else begin
                    chk(src_ready == exp_rdy, "R6/R7/R10", "src_ready", src_ready, exp_rdy);
                    chk(out_valid == m_ov, "R5/R8/R9", "out_valid", out_valid, m_ov);
                    if (m_ov && out_valid) begin
                        chk(out_data == m_od, "R2/R3", "out_data", out_data, m_od);
                        chk(out_data[31:28] == 4'hA, "R4", "sync marker", out_data[31:28], 4'hA);
                        if (out_ready) frames_seen++;
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                if (srcq[i].size() > 0 && ($urandom % 100) < p_valid) begin
                    src_valid[i] = 1'b1;
                    {src_last[i], src_data[i*32 +: 32]} = srcq[i][0];
                end else begin
                    src_valid[i] = 1'b0;
                    src_last[i]  = 1'b0;
                    src_data[i*32 +: 32] = $urandom;
                end
            end
            out_ready = (($urandom % 100) < p_ready);
        end
    end

    task automatic push(int s, int n, int plen);
        for (int k = 0; k < n; k++)
            srcq[s].push_back({((k % plen) == plen - 1) || (k == n - 1),
                               8'(s), 8'(plen), 16'(k)});
    endtask

    function automatic bit all_empty();
        for (int i = 0; i < N; i++) if (srcq[i].size() != 0) return 0;
        return 1;
    endfunction

    task automatic drain();
        while (!all_empty()) @(negedge clk);
        p_ready = 100;
        repeat (int'(cfg_idle_limit) + 20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        src_valid = '1;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R5: exactly one full frame from one producer
        p_valid = 100; p_ready = 100;
        push(1, 7, 7);
        drain();
        chk(frames_seen == 1, "R5", "full frame count", 256'(frames_seen), 256'd1);

        // R8: partial frame released by the idle limit
        cfg_idle_limit = 16'd5;
        push(2, 3, 3);
        drain();
        chk(frames_seen == 2, "R8", "flush frame count", 256'(frames_seen), 256'd2);

        // R6: single-word packets from every producer at once
        for (int i = 0; i < N; i++) push(i, 6, 1);
        drain();

        // R7, R9: long packets, random valid and back-pressure
        p_valid = 60; p_ready = 40;
        for (int i = 0; i < N; i++) push(i, 40, 5 + i);
        drain();

        // R8: limits of 0 and 1 with sparse traffic
        p_valid = 20; p_ready = 70;
        cfg_idle_limit = 16'd0;
        for (int i = 0; i < N; i++) push(i, 12, 3);
        drain();
        cfg_idle_limit = 16'd1;
        for (int i = 0; i < N; i++) push(i, 12, 2);
        drain();

        // R9: heavy stall with mixed packets
        p_valid = 90; p_ready = 10;
        cfg_idle_limit = 16'd9;
        for (int i = 0; i < N; i++) push(i, 30, 1 + 3 * i);
        drain();

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule